// File: doc/BRIEF.md
# Stream Memory Address Generator

This block turns a stream descriptor into a sequence of word addresses, one request per word, for a transfer between external memory and an on-chip stream buffer. A descriptor gives a base word address, a first and last record index, a stride, the number of words per record and an access mode. In sequential mode every record between the two bounds is visited. In strided mode the record index steps by the stride. In indexed mode (gather/scatter) the record indices arrive one at a time on a separate index stream.

Each record is issued as a block of consecutive word addresses before the next record begins. Every address waits on a valid/ready handshake. A single-cycle done pulse marks the end of the stream. Two copies can run side by side as independent address generators of one memory system. The block moves no data.

Top module: `stream_agen`

## Requirements
- R1: After reset the block is idle: desc_ready is 1, and addr_valid, idx_ready and done are 0.
- R2: Each issued address equals base + record_index × record_words + word_offset, truncated to the address width, where word_offset counts from 0.
- R3: In sequential mode (desc_mode = 0, and also the unused code 3) the records from start to end, both included, are visited in ascending order. The stride field is ignored.
- R4: In strided mode (desc_mode = 1) the record index begins at start and grows by the stride while it stays at or below end. A stride of 0 acts as a stride of 1.
- R5: In indexed mode (desc_mode = 2) start, end and stride are ignored. Each index beat with idx_last = 0 supplies one record index, used in arrival order. A beat with idx_last = 1 ends the stream and carries no record.
- R6: All record_words words of a record are issued with consecutive offsets before any word of the next record. A record_words value of 0 acts as 1.
- R7: While addr_valid is 1 and addr_ready is 0, addr_valid stays 1 and addr_out holds its value.
- R8: In indexed mode, while an index is awaited (idx_ready = 1), no address is offered. A gap in idx_valid delays the stream without losing or reordering records.
- R9: In sequential or strided mode with start > end, no address is issued, and done is 1 in the cycle after the descriptor is taken.
- R10: In indexed mode, when the first index beat is the terminator, no address is issued, and done is 1 in the cycle after that beat is taken.
- R11: done is 1 for exactly one cycle, the one after the final handshake (last word, or terminator beat), and the block is idle in the next cycle. desc_ready is 1 only when idle, and a descriptor offered while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle, descriptor taken on valid |
| desc_mode | input | 2 | 0 sequential, 1 strided, 2 indexed, 3 as sequential |
| desc_base | input | AW | Base word address |
| desc_start | input | IW | First record index |
| desc_end | input | IW | Last record index (inclusive) |
| desc_stride | input | IW | Record step in strided mode |
| desc_words | input | WW | Words per record |
| idx_valid | input | 1 | Index beat valid |
| idx_ready | output | 1 | Generator waiting for an index beat |
| idx_value | input | IW | Record index of the beat |
| idx_last | input | 1 | Terminator beat, no record |
| addr_valid | output | 1 | Address request valid |
| addr_ready | input | 1 | Address request accepted |
| addr_out | output | AW | Word address |
| done | output | 1 | One-cycle end-of-stream pulse |

## Verification
The hardest case to reach is an indexed stream where index gaps and address backpressure overlap. A record must then survive a stall on both sides, and the terminator must still produce done exactly one cycle after its handshake. The bench gets there by gating idx_valid with a periodic gap while addr_ready drops every third cycle. It also offers a stray descriptor in the middle of a run. Each handshake is logged by cycle, so the done timing is measured from the final handshake, whichever port carried it.

// File: rtl/stream_agen.sv
module stream_agen #(
  parameter int AW = 32,
  parameter int IW = 16,
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desc_valid,
  output logic          desc_ready,
  input  logic [1:0]    desc_mode,
  input  logic [AW-1:0] desc_base,
  input  logic [IW-1:0] desc_start,
  input  logic [IW-1:0] desc_end,
  input  logic [IW-1:0] desc_stride,
  input  logic [WW-1:0] desc_words,
  input  logic          idx_valid,
  output logic          idx_ready,
  input  logic [IW-1:0] idx_value,
  input  logic          idx_last,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-1:0] addr_out,
  output logic          done
);
  localparam logic [1:0] MODE_STRIDE = 2'd1;
  localparam logic [1:0] MODE_INDEX  = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FETCH, S_FIN} st_t;

  st_t           st;
  logic [AW-1:0] base_q;
  logic [IW-1:0] rec_q, end_q, stride_q;
  logic [WW-1:0] words_q, woff_q;
  logic          indexed_q;

  logic [IW:0] nxt_rec;
  logic        last_word;

  assign nxt_rec    = {1'b0, rec_q} + {1'b0, stride_q};
  assign last_word  = woff_q == words_q - 1'b1;
  assign desc_ready = st == S_IDLE;
  assign idx_ready  = st == S_FETCH;
  assign addr_valid = st == S_RUN;
  assign done       = st == S_FIN;
  assign addr_out   = base_q + AW'(rec_q) * AW'(words_q) + AW'(woff_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      base_q    <= '0;
      rec_q     <= '0;
      end_q     <= '0;
      stride_q  <= '0;
      words_q   <= '0;
      woff_q    <= '0;
      indexed_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (desc_valid) begin
          base_q    <= desc_base;
          rec_q     <= desc_start;
          end_q     <= desc_end;
          woff_q    <= '0;
          words_q   <= (desc_words == '0) ? WW'(1) : desc_words;
          stride_q  <= (desc_mode == MODE_STRIDE && desc_stride != '0) ? desc_stride : IW'(1);
          indexed_q <= desc_mode == MODE_INDEX;
          if (desc_mode == MODE_INDEX)   st <= S_FETCH;
          else if (desc_start > desc_end) st <= S_FIN;
          else                            st <= S_RUN;
        end
        S_FETCH: if (idx_valid) begin
          if (idx_last) st <= S_FIN;
          else begin
            rec_q  <= idx_value;
            woff_q <= '0;
            st     <= S_RUN;
          end
        end
        S_RUN: if (addr_ready) begin
          if (!last_word) woff_q <= woff_q + 1'b1;
          else begin
            woff_q <= '0;
            if (indexed_q) st <= S_FETCH;
            else if (nxt_rec > {1'b0, end_q}) st <= S_FIN;
            else rec_q <= nxt_rec[IW-1:0];
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stream_agen_checker.sv
module stream_agen_checker #(
  parameter int AW = 32,
  parameter int WW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic [AW-1:0] addr_out,
  input logic          done,
  input logic          desc_ready,
  input logic          idx_ready,
  input logic [WW-1:0] woff_q,
  input logic [WW-1:0] words_q
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready |-> (!addr_valid && !idx_ready));

  p_word_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready && woff_q != words_q - 1'b1) |=>
      (addr_valid && addr_out == $past(addr_out) + 1'b1));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_out)));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ready |-> !addr_valid);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && desc_ready));

  p_done_alone_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done, desc_ready, idx_ready, addr_valid}) == 1);
endmodule

bind stream_agen stream_agen_checker #(.AW(AW), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_ready(addr_ready),
  .addr_out(addr_out), .done(done), .desc_ready(desc_ready), .idx_ready(idx_ready),
  .woff_q(woff_q), .words_q(words_q)
);

// File: tb/stream_agen_bench.sv
`timescale 1ns/1ps
module stream_agen_bench;
  logic        clk = 0, rst_n = 0;
  logic        desc_valid = 0, desc_ready;
  logic [1:0]  desc_mode = 0;
  logic [31:0] desc_base = 0;
  logic [15:0] desc_start = 0, desc_end = 0, desc_stride = 0;
  logic [7:0]  desc_words = 0;
  logic        idx_valid = 0, idx_ready, idx_last = 0;
  logic [15:0] idx_value = 0;
  logic        addr_valid, addr_ready = 0, done;
  logic [31:0] addr_out;

  always #2 clk = ~clk;

  stream_agen u_stream_agen (.*);

  int checks = 0, fails = 0;
  logic [31:0] exp_a [0:63];
  int nexp;
  logic [15:0] ival [0:15];

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic build_lin(input int base, input int s, input int e, input int stride, input int w);
    int ww = (w == 0) ? 1 : w;
    int st = (stride == 0) ? 1 : stride;
    nexp = 0;
    for (int r = s; r <= e; r += st)
      for (int k = 0; k < ww; k++) begin exp_a[nexp] = base + r * ww + k; nexp++; end
  endtask

  task automatic build_idx(input int base, input int w, input int n);
    int ww = (w == 0) ? 1 : w;
    nexp = 0;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < ww; k++) begin exp_a[nexp] = base + ival[i] * ww + k; nexp++; end
  endtask

  task automatic send(input logic [1:0] m, input int base, input int s, input int e,
                      input int stride, input int w);
    desc_mode = m; desc_base = base; desc_start = s; desc_end = e;
    desc_stride = stride; desc_words = w; desc_valid = 1;
    chk(desc_ready, "R11 idle ready", desc_ready, 1);
    @(negedge clk);
    desc_valid = 0;
  endtask

  task automatic run(input bit bp, input int gap, input bit poke, input int nidx);
    int ip = 0, it = 0, last_ev = -1, n = 0;
    bit fin = 0, hold = 0;
    logic [31:0] hold_a = 0;
    while (!fin && it < 3000) begin
      if (done) begin
        chk(n == nexp, "R11 word count at done", n, nexp);
        chk(it == last_ev + 1, "R9/R10/R11 done timing", it, last_ev + 1);
        fin = 1;
      end else begin
        if (hold) chk(addr_valid && addr_out == hold_a, "R7 hold", addr_out, hold_a);
        addr_ready = !bp || (it % 3 != 1);
        if (ip <= nidx && (gap == 0 || it % gap != 0)) begin
          idx_valid = 1; idx_last = (ip == nidx);
          idx_value = (ip < nidx) ? ival[ip] : 16'hBEEF;
        end else idx_valid = 0;
        if (poke && it == 2) begin
          desc_valid = 1; desc_base = 32'h5555_0000; desc_mode = 0;
          chk(!desc_ready, "R11 busy not ready", desc_ready, 0);
        end
        if (poke && it == 3) desc_valid = 0;
        if (idx_ready) chk(!addr_valid, "R8 no address while awaiting index", addr_valid, 0);
        hold = addr_valid && !addr_ready;
        hold_a = addr_out;
        if (addr_valid && addr_ready) begin
          if (n < nexp) chk(addr_out == exp_a[n], "R2/R3/R4/R5/R6 address", addr_out, exp_a[n]);
          else chk(0, "R9/R10/R11 extra address", addr_out, 0);
          n++; last_ev = it;
        end
        if (idx_valid && idx_ready) begin ip++; last_ev = it; end
        @(negedge clk); it++;
      end
    end
    if (!fin) chk(0, "R11 done never seen", 0, 1);
    idx_valid = 0; desc_valid = 0; addr_ready = 0;
    @(negedge clk);
    chk(!done && desc_ready, "R11 single pulse then idle", {done, desc_ready}, 1);
  endtask

  task t_reset; // R1
    chk(desc_ready && !addr_valid && !idx_ready && !done, "R1 reset state",
        {desc_ready, addr_valid, idx_ready, done}, 4'b1000);
  endtask

  task t_seq; // R2 R3 R6
    build_lin(32'h1000, 2, 5, 1, 3); send(0, 32'h1000, 2, 5, 9, 3); run(0, 0, 0, -1);
    build_lin(32'h40, 0, 2, 1, 2);   send(3, 32'h40, 0, 2, 5, 2);   run(0, 0, 0, -1);
  endtask

  task t_seq_bp; // R7 R11
    build_lin(32'h2000, 1, 4, 1, 4); send(0, 32'h2000, 1, 4, 0, 4); run(1, 0, 1, -1);
  endtask

  task t_stride; // R4
    build_lin(32'h300, 1, 10, 4, 2); send(1, 32'h300, 1, 10, 4, 2); run(1, 0, 0, -1);
    build_lin(32'h300, 0, 8, 4, 1);  send(1, 32'h300, 0, 8, 4, 1);  run(0, 0, 0, -1);
    build_lin(32'h10, 3, 5, 0, 1);   send(1, 32'h10, 3, 5, 0, 1);   run(0, 0, 0, -1);
  endtask

  task t_words0; // R6
    build_lin(32'h80, 4, 6, 1, 0); send(0, 32'h80, 4, 6, 0, 0); run(0, 0, 0, -1);
  endtask

  task t_index; // R5 R8
    ival[0] = 7; ival[1] = 2; ival[2] = 9; ival[3] = 2;
    build_idx(32'h4000, 2, 4); send(2, 32'h4000, 50, 1, 3, 2); run(1, 3, 1, 4);
    build_idx(32'h100, 3, 2);  send(2, 32'h100, 0, 0, 0, 3);   run(0, 0, 0, 2);
  endtask

  task t_empty; // R9 R10
    nexp = 0; send(0, 32'h0, 5, 3, 1, 2); run(0, 0, 0, -1);
    nexp = 0; send(1, 32'h0, 9, 2, 2, 2); run(0, 0, 0, -1);
    nexp = 0; send(2, 32'h0, 0, 9, 1, 2); run(0, 2, 0, 0);
  endtask

  initial begin
    #40000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_seq();
    t_seq_bp();
    t_stride();
    t_words0();
    t_index();
    t_empty();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule